// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block is the digital side of a two-input, 12-bit successive-approximation converter that a host reads over a three-wire serial link. The host lowers an active-low select line, clocks a 16-bit word out of the block and raises the select line again. While select is high the block sleeps and leaves its data pin undriven. The level of the serial clock at the moment select falls sets who paces the conversion. A high clock means a local oscillator paces it: the host waits for an end-of-conversion mark and then reads at any rate. A low clock means the host's serial clock itself paces the conversion.

The analog side is replaced by a behavioural approximation stub. On each step it compares a trial code against a held copy of the `sample_word_i` input, so that the bits of the result appear in the same order a real converter would settle them. The serial inputs pass through two-flop synchronisers into the system clock. The local oscillator is a clock-enable divider of the system clock.

Top module: `sadc_ctrl`

## Requirements
- R1: When the synchronised select line falls, the synchronised serial clock level selects the mode for that access: high selects oscillator pacing and low selects host-clock pacing.
- R2: The data output carries frame bits 1 to 16 in order. Bits 1, 2 and 3 are 1, bit 4 is the input identifier (0 for input 0, 1 for input 1), and bits 5 to 16 are the result from bit 11 down to bit 0.
- R3: While select is high, `dout_oe_o` is 0, `shdn_o` is 1 and `dout_o` is 0. While select is low, `dout_oe_o` is 1 and `shdn_o` is 0.
- R4: The first access after reset reports input 0. Every later select-low access reports the other input from the one before it, and an aborted access also counts as an access.
- R5: In oscillator mode, the first serial clock falling edge captures `sample_word_i` and starts the conversion. During the conversion `busy_o` is 1 and `dout_o` is 0. After 12 oscillator ticks of OSC_DIV system cycles each, `dout_o` goes to 1 as frame bit 1, and each later falling edge presents the next frame bit.
- R6: In host-clock mode, frame bit n appears after falling edge n. `sample_word_i` is captured at falling edge 2, so changes after that edge do not affect the result.
- R7: After frame bit 16, further falling edges with select still low present 0.
- R8: Raising select during a conversion abandons it. `busy_o` drops to 0 and `shdn_o` rises, and the next access completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low select / sleep line, asynchronous |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| sample_word_i | input | DATA_W | Word standing in for the analog input |
| dout_o | output | 1 | Serial data bit |
| dout_oe_o | output | 1 | Drive enable for the data pad |
| busy_o | output | 1 | Conversion in progress |
| shdn_o | output | 1 | Block asleep (select high) |

## Verification
The hardest situation to reach is an abort in the middle of an oscillator-paced conversion. The window lasts only 12·OSC_DIV system cycles and starts a few synchroniser cycles after the first falling edge. The stimulus confirms `busy_o` inside that window and then raises select. A full frame follows, which must show the next input identifier and a clean result. The capture instants are checked by changing `sample_word_i` immediately after the edge that should capture it and expecting the old value in the frame.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_ACQ   = 2'd1,
    ST_CONV  = 2'd2,
    ST_READ  = 2'd3
  } sadc_state_t;

  localparam int LEAD_ONES = 3;
endpackage

// File: rtl/sadc_edge_sync.sv
module sadc_edge_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic lvl_o,
  output logic prev_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
      s3_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign prev_o = s3_q;
endmodule

// File: rtl/sadc_osc_div.sv
module sadc_osc_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/sadc_sar_stub.sv
module sadc_sar_stub #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         step_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] res_o,
  output logic         done_o
);
  localparam int PW = $clog2(W);

  logic [W-1:0]  held_q, res_q, trial;
  logic [PW-1:0] ptr_q;
  logic          done_q;

  assign trial = res_q | (W'(1) << ptr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      res_q  <= '0;
      ptr_q  <= '0;
      done_q <= 1'b1;
    end else if (start_i) begin
      held_q <= word_i;
      res_q  <= '0;
      ptr_q  <= PW'(W - 1);
      done_q <= 1'b0;
    end else if (step_i && !done_q) begin
      if (trial <= held_q) res_q <= trial;
      if (ptr_q == '0) done_q <= 1'b1;
      else             ptr_q  <= ptr_q - 1'b1;
    end
  end

  assign res_o  = res_q;
  assign done_o = done_q;
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int OSC_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_word_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              busy_o,
  output logic              shdn_o
);
  localparam int FRAME_LEN = LEAD_ONES + 1 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN + 2);
  localparam int VEC_N     = 1 << IDX_W;
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(FRAME_LEN + 1);

  logic cs_lvl, cs_prev, sclk_lvl, sclk_prev;
  logic cs_fall, cs_rise, sclk_fall;

  sadc_edge_sync #(.RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .d_i(cs_n_i), .lvl_o(cs_lvl), .prev_o(cs_prev)
  );
  sadc_edge_sync #(.RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst(rst), .d_i(sclk_i), .lvl_o(sclk_lvl), .prev_o(sclk_prev)
  );

  assign cs_fall   = cs_prev & ~cs_lvl;
  assign cs_rise   = ~cs_prev & cs_lvl;
  assign sclk_fall = sclk_prev & ~sclk_lvl;

  sadc_state_t       state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              ext_q, ext_d;
  logic              ch_q, ch_d;
  logic              dout_q;
  logic              sar_start, sar_step, sar_done, osc_tick;
  logic [DATA_W-1:0] sar_res;
  logic [VEC_N-1:0]  frame_vec;

  sadc_osc_div #(.DIV(OSC_DIV)) u_osc (
    .clk(clk), .rst(rst), .run_i(state_q == ST_CONV), .tick_o(osc_tick)
  );

  sadc_sar_stub #(.W(DATA_W)) u_sar (
    .clk(clk), .rst(rst), .start_i(sar_start), .step_i(sar_step),
    .word_i(sample_word_i), .res_o(sar_res), .done_o(sar_done)
  );

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    ext_d     = ext_q;
    ch_d      = ch_q;
    sar_start = 1'b0;
    sar_step  = 1'b0;
    if (cs_rise) begin
      state_d = ST_SLEEP;
    end else begin
      case (state_q)
        ST_SLEEP: if (cs_fall) begin
          ch_d    = ~ch_q;
          ext_d   = ~sclk_lvl;
          idx_d   = '0;
          state_d = sclk_lvl ? ST_ACQ : ST_READ;
        end
        ST_ACQ: if (sclk_fall) begin
          sar_start = 1'b1;
          state_d   = ST_CONV;
        end
        ST_CONV: begin
          sar_step = osc_tick;
          if (sar_done) begin
            state_d = ST_READ;
            idx_d   = IDX_W'(1);
          end
        end
        ST_READ: if (sclk_fall) begin
          if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
          if (ext_q) begin
            if (idx_q == IDX_W'(1))       sar_start = 1'b1;
            else if (idx_q >= IDX_W'(2))  sar_step  = 1'b1;
          end
        end
        default: state_d = ST_SLEEP;
      endcase
    end
  end

  always_comb begin
    frame_vec = '0;
    for (int k = 1; k <= LEAD_ONES; k++) frame_vec[k] = 1'b1;
    frame_vec[LEAD_ONES + 1] = ch_d;
    for (int j = 0; j < DATA_W; j++) frame_vec[LEAD_ONES + 2 + j] = sar_res[DATA_W - 1 - j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SLEEP;
      idx_q   <= '0;
      ext_q   <= 1'b0;
      ch_q    <= 1'b1;
      dout_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ext_q   <= ext_d;
      ch_q    <= ch_d;
      dout_q  <= (state_d == ST_READ) ? frame_vec[idx_d] : 1'b0;
    end
  end

  assign dout_o    = dout_q;
  assign dout_oe_o = (state_q != ST_SLEEP);
  assign busy_o    = (state_q == ST_CONV);
  assign shdn_o    = (state_q == ST_SLEEP);
endmodule

// File: rtl/sadc_ctrl_chk.sv
module sadc_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic dout,
  input logic oe,
  input logic busy,
  input logic shdn,
  input logic cs_rise
);
  assert_quiet_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !dout);

  assert_low_in_conv_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> !dout);

  assert_eoc_mark_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !shdn) |-> dout);

  assert_abort_sleeps_R8: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> (shdn && !busy));
endmodule

bind sadc_ctrl sadc_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .dout(dout_o), .oe(dout_oe_o),
  .busy(busy_o), .shdn(shdn_o), .cs_rise(cs_rise)
);

// File: tb/sadc_ctrl_tb.sv
module sadc_ctrl_tb;
  localparam int W   = 12;
  localparam int DIV = 4;
  localparam int H   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic [W-1:0] word = '0;
  logic dout, oe, busy, shdn;

  int tests = 0;
  int fails = 0;
  logic ch_next = 1'b0;

  always #2.5 clk = ~clk;

  sadc_ctrl #(.DATA_W(W), .OSC_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .sample_word_i(word),
    .dout_o(dout), .dout_oe_o(oe), .busy_o(busy), .shdn_o(shdn)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_frame(input logic ch, input logic [W-1:0] code);
    return {3'b111, ch, code};
  endfunction

  task automatic do_frame(input logic imode, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [15:0] got;
    logic ch;
    int n;
    got = '0;
    ch = ch_next;
    ch_next = ~ch_next;
    word = a;
    sclk = imode;
    wait_h();
    cs_n = 1'b0;
    wait_h();
    check("R3 oe on", {31'd0, oe}, 32'd1);
    check("R3 shdn off", {31'd0, shdn}, 32'd0);
    if (imode) begin
      sclk = 1'b0;
      n = 0;
      wait_h();
      n += H;
      word = b;
      check("R5 busy", {31'd0, busy}, 32'd1);
      sclk = 1'b1;
      while (dout !== 1'b1 && n < 400) begin
        @(negedge clk);
        n++;
      end
      check("R5 eoc not early", {31'd0, n >= 12 * DIV}, 32'd1);
      check("R5 eoc not late", {31'd0, n <= 12 * DIV + 12}, 32'd1);
      got[15] = dout;
      for (int i = 2; i <= 16; i++) begin
        sclk = 1'b0;
        wait_h();
        got[16 - i] = dout;
        sclk = 1'b1;
        wait_h();
      end
      check("R1 R2 R4 R5 frame", {16'd0, got}, {16'd0, exp_frame(ch, a)});
      for (int t = 0; t < 3; t++) begin
        sclk = 1'b0;
        wait_h();
        check("R7 trailing", {31'd0, dout}, 32'd0);
        sclk = 1'b1;
        wait_h();
      end
    end else begin
      for (int i = 1; i <= 16; i++) begin
        sclk = 1'b1;
        wait_h();
        sclk = 1'b0;
        wait_h();
        got[16 - i] = dout;
        if (i == 2) word = b;
      end
      check("R1 R2 R4 R6 frame", {16'd0, got}, {16'd0, exp_frame(ch, a)});
      for (int t = 0; t < 3; t++) begin
        sclk = 1'b1;
        wait_h();
        sclk = 1'b0;
        wait_h();
        check("R7 trailing", {31'd0, dout}, 32'd0);
      end
    end
    cs_n = 1'b1;
    wait_h();
    check("R3 oe off", {31'd0, oe}, 32'd0);
    check("R3 shdn on", {31'd0, shdn}, 32'd1);
    check("R3 dout low", {31'd0, dout}, 32'd0);
  endtask

  task automatic do_abort();
    ch_next = ~ch_next;
    word = 12'h5A5;
    sclk = 1'b1;
    wait_h();
    cs_n = 1'b0;
    wait_h();
    sclk = 1'b0;
    wait_h();
    check("R8 converting", {31'd0, busy}, 32'd1);
    cs_n = 1'b1;
    wait_h();
    check("R8 busy dropped", {31'd0, busy}, 32'd0);
    check("R8 asleep", {31'd0, shdn}, 32'd1);
    check("R8 pad off", {31'd0, oe}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] a;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    wait_h();
    check("R3 reset oe", {31'd0, oe}, 32'd0);
    check("R3 reset shdn", {31'd0, shdn}, 32'd1);
    check("R3 reset busy", {31'd0, busy}, 32'd0);
    do_frame(1'b0, 12'hFFF, 12'h000);
    do_frame(1'b1, 12'h000, 12'hFFF);
    do_frame(1'b1, 12'h800, 12'h7FF);
    do_frame(1'b0, 12'h7FF, 12'h800);
    do_abort();
    do_frame(1'b1, 12'hAAA, 12'h555);
    do_abort();
    do_frame(1'b0, 12'h555, 12'hAAA);
    for (int k = 0; k < 40; k++) begin
      a = W'((k * 12'h0A7) ^ (k << 7));
      do_frame(k[0] ^ k[2], a, ~a);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule